// File: doc/BRIEF.md
# Serial Divider-Ratio Load Port

This block receives divide ratios for a frequency synthesizer over a three-wire serial port made of a serial clock, a serial data line and a load-enable line. All three wires are sampled in the block's own clock domain. Each rising edge of the serial clock moves one data bit into a 19-position shift register. Once a full frame is in, the last position holds a selector bit, and the 18 positions below it hold the ratio payload.

While load-enable is high, the selector bit picks one of two holding registers, and that register follows the shift register. Selector 1 picks the 14-bit reference ratio. Selector 0 picks the main divider word, which is split into a 6-bit swallow count and a 12-bit programmable count. The other register keeps its value. Each holding register has a sticky valid flag and a one-cycle load strobe, so the counters that use these values can tell when a value has arrived and when it changes. Neither register holds a usable value until it has been loaded once, so after start-up software sends two frames, with a load-enable pulse after each.

Top module: `ratio_load_port`

## Requirements
- R1: A bit is taken from the serial data line only on a rising edge of the serial clock. Bits arrive least significant first, and the 19th bit of a frame is the selector. Without a serial-clock rising edge, the stored frame does not change.
- R2: When load-enable is high and the stored selector is 0, the main divider register takes the payload. The reference ratio outputs keep their value.
- R3: When load-enable is high and the stored selector is 1, the reference ratio register takes payload bits 13..0. Payload bits 17..14 are ignored, and the swallow and programmable count outputs keep their value.
- R4: In the main payload, bits 5..0 (the first six bits sent) are the swallow count, and bits 17..6 are the programmable count. The reference ratio is plain binary with bit 0 sent first, so a ratio of 5 is sent as 1, 0, 1 followed by zeros.
- R5: While load-enable stays high, each further serial-clock rising edge shifts the frame again. The register chosen by the new selector then follows the new payload, and the other register is not touched.
- R6: While load-enable is low, neither holding register changes, however many bits are shifted in.
- R7: A synchronous active-high reset clears both holding registers, both valid flags and both strobes.
- R8: The valid flag of a holding register rises when that register is first loaded, and it stays high until reset. Shifting a frame with no load-enable pulse does not set it.
- R9: Each load-enable pulse produces exactly one one-cycle strobe, on the load output of the selected register only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial wires |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock; a bit is taken on its rising edge |
| ser_dat | input | 1 | Serial data, least significant bit first |
| ser_le | input | 1 | Load enable; high opens the selected holding register |
| ref_ratio | output | 14 | Latched reference divide ratio |
| swallow_cnt | output | 6 | Latched swallow count |
| prog_cnt | output | 12 | Latched programmable count |
| ref_valid | output | 1 | Reference ratio loaded at least once since reset |
| main_valid | output | 1 | Main divider word loaded at least once since reset |
| ref_load | output | 1 | One-cycle strobe when the reference register is opened |
| main_load | output | 1 | One-cycle strobe when the main register is opened |

## Verification
The hardest case to reach is shifting while load-enable is already high. There the selector bit itself moves one place on each edge, and the open register follows a payload that is changing. The stimulus loads a known main frame, holds load-enable high, and sends one more zero bit. The main outputs must then show the payload shifted down by one with a zero on top, and the reference ratio must stay as it was. The swallow field is swept through all 64 values and the reference ratio through walking ones, so every field position is checked against an arithmetic expectation.

// File: rtl/ratio_load_pkg.sv
package ratio_load_pkg;
  localparam int A_BITS = 6;
  localparam int N_BITS = 12;
  localparam int R_BITS = 14;
  localparam int MAIN_BITS = A_BITS + N_BITS;
  localparam int PAY_BITS = (MAIN_BITS > R_BITS) ? MAIN_BITS : R_BITS;
  localparam int FRAME_BITS = PAY_BITS + 1;

  typedef enum logic {
    SEL_MAIN = 1'b0,
    SEL_REF  = 1'b1
  } latch_sel_e;
endpackage

// File: rtl/wire_sync.sv
module wire_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0] chain [WIDTH];

  for (genvar w = 0; w < WIDTH; w++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) chain[w] <= '0;
      else     chain[w] <= {chain[w][STAGES-2:0], din[w]};
    end
    assign dout[w] = chain[w][STAGES-1];
  end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int FRAME_W = 19
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               sdat_s,
  output logic [FRAME_W-1:0] frame,
  output logic               shift_en
);
  logic sclk_d;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign shift_en = sclk_s & ~sclk_d;

  always_ff @(posedge clk) begin
    if (rst)           frame <= '0;
    else if (shift_en) frame <= {sdat_s, frame[FRAME_W-1:1]};
  end

  AST_FRAME_STILL: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(frame)); // R1
endmodule

// File: rtl/hold_latch.sv
module hold_latch #(
  parameter int WIDTH = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             valid,
  output logic             stb
);
  logic en_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      valid <= 1'b0;
      stb   <= 1'b0;
      en_d  <= 1'b0;
    end else begin
      en_d <= en;
      stb  <= en & ~en_d;
      if (en) begin
        q     <= d;
        valid <= 1'b1;
      end
    end
  end

  AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q)); // R6
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid); // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (q == '0 && !valid && !stb)); // R7
endmodule

// File: rtl/ratio_load_port.sv
module ratio_load_port
  import ratio_load_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_le,
  output logic [R_BITS-1:0] ref_ratio,
  output logic [A_BITS-1:0] swallow_cnt,
  output logic [N_BITS-1:0] prog_cnt,
  output logic              ref_valid,
  output logic              main_valid,
  output logic              ref_load,
  output logic              main_load
);
  logic [2:0]            wires_s;
  logic [FRAME_BITS-1:0] frame;
  logic                  shift_en;
  latch_sel_e            sel;
  logic                  ref_en, main_en;
  logic [MAIN_BITS-1:0]  main_q;

  wire_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({ser_le, ser_dat, ser_clk}),
    .dout(wires_s)
  );

  frame_shifter #(.FRAME_W(FRAME_BITS)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .sclk_s  (wires_s[0]),
    .sdat_s  (wires_s[1]),
    .frame   (frame),
    .shift_en(shift_en)
  );

  assign sel     = latch_sel_e'(frame[FRAME_BITS-1]);
  assign ref_en  = wires_s[2] & (sel == SEL_REF);
  assign main_en = wires_s[2] & (sel == SEL_MAIN);

  hold_latch #(.WIDTH(R_BITS)) u_ref (
    .clk  (clk),
    .rst  (rst),
    .en   (ref_en),
    .d    (frame[R_BITS-1:0]),
    .q    (ref_ratio),
    .valid(ref_valid),
    .stb  (ref_load)
  );

  hold_latch #(.WIDTH(MAIN_BITS)) u_main (
    .clk  (clk),
    .rst  (rst),
    .en   (main_en),
    .d    (frame[MAIN_BITS-1:0]),
    .q    (main_q),
    .valid(main_valid),
    .stb  (main_load)
  );

  assign swallow_cnt = main_q[A_BITS-1:0];
  assign prog_cnt    = main_q[MAIN_BITS-1:A_BITS];

  AST_ONE_LATCH_OPEN: assert property (@(posedge clk) disable iff (rst)
    !(ref_load && main_load)); // R9
  AST_REF_KEEPS_ON_MAIN: assert property (@(posedge clk) disable iff (rst)
    main_en |=> $stable(ref_ratio)); // R2
  AST_MAIN_KEEPS_ON_REF: assert property (@(posedge clk) disable iff (rst)
    ref_en |=> ($stable(swallow_cnt) && $stable(prog_cnt))); // R3
endmodule

// File: tb/ratio_load_port_test.sv
module ratio_load_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [13:0] ref_ratio;
  logic [5:0]  swallow_cnt;
  logic [11:0] prog_cnt;
  logic ref_valid, main_valid, ref_load, main_load;

  int n_tests = 0;
  int n_fail = 0;
  int ref_pulses = 0;
  int main_pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ratio_load_port uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .ref_ratio(ref_ratio), .swallow_cnt(swallow_cnt), .prog_cnt(prog_cnt),
    .ref_valid(ref_valid), .main_valid(main_valid),
    .ref_load(ref_load), .main_load(main_load)
  );

  always @(posedge clk) begin
    if (ref_load)  ref_pulses++;
    if (main_load) main_pulses++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    wait_clk(GAP);
    ser_clk = 1'b1;
    wait_clk(GAP);
    ser_clk = 1'b0;
    wait_clk(GAP);
  endtask

  task automatic send_frame(input logic [17:0] pay, input logic sel);
    for (int i = 0; i < 18; i++) send_bit(pay[i]);
    send_bit(sel);
  endtask

  task automatic pulse_le();
    ser_le = 1'b1;
    wait_clk(GAP);
    ser_le = 1'b0;
    wait_clk(GAP);
  endtask

  logic [13:0] exp_r;
  logic [5:0]  exp_a;
  logic [11:0] exp_n;
  int rp0, mp0;

  initial begin
    fork
      begin
        wait_clk(3);
        rst = 1'b0;
        wait_clk(2);
        // R7 reset state
        chk("R7 ref_ratio", ref_ratio, 0);
        chk("R7 main", {swallow_cnt, prog_cnt}, 0);
        chk("R7 valids", {ref_valid, main_valid}, 0);
        chk("R7 strobes", {ref_load, main_load}, 0);

        // R8/R6 frame without load enable changes nothing
        send_frame(18'h2AAAA, 1'b1);
        chk("R6 ref held", ref_ratio, 0);
        chk("R8 no valid without le", {ref_valid, main_valid}, 0);

        // R4 reference ratio of 5, bit 0 first; upper payload bits ignored (R3)
        send_frame({4'hF, 14'd5}, 1'b1);
        rp0 = ref_pulses; mp0 = main_pulses;
        pulse_le();
        chk("R4 ref=5", ref_ratio, 5);
        chk("R8 ref_valid", {ref_valid, main_valid}, 2'b10);
        chk("R9 one ref strobe", ref_pulses - rp0, 1);
        chk("R9 no main strobe", main_pulses - mp0, 0);
        chk("R3 main untouched", {swallow_cnt, prog_cnt}, 0);
        exp_r = 14'd5;

        // R2/R4 sweep every swallow value with varying N
        for (int a = 0; a < 64; a++) begin
          exp_a = a[5:0];
          exp_n = 12'(a * 61 + 5);
          send_frame({exp_n, exp_a}, 1'b0);
          rp0 = ref_pulses; mp0 = main_pulses;
          pulse_le();
          chk("R4 swallow", swallow_cnt, exp_a);
          chk("R4 prog", prog_cnt, exp_n);
          chk("R2 ref held", ref_ratio, exp_r);
          chk("R9 main strobe", main_pulses - mp0, 1);
          chk("R9 ref quiet", ref_pulses - rp0, 0);
        end
        chk("R8 both valid", {ref_valid, main_valid}, 2'b11);

        // R3/R4 walking ones in reference ratio
        for (int k = 0; k < 14; k++) begin
          exp_r = 14'(1 << k);
          send_frame({4'h0, exp_r}, 1'b1);
          pulse_le();
          chk("R3 ref walk", ref_ratio, exp_r);
          chk("R3 main held", {swallow_cnt, prog_cnt}, {exp_a, exp_n});
        end

        // R6 shifting with le low leaves both registers
        send_frame(18'h3FFFF, 1'b0);
        chk("R6 main held", {prog_cnt, swallow_cnt}, {exp_n, exp_a});
        chk("R6 ref held", ref_ratio, exp_r);

        // R5 shift while le high: selector stays 0, payload moves down one
        send_frame({12'hC35, 6'h2B}, 1'b0);
        ser_le = 1'b1;
        wait_clk(GAP);
        chk("R5 open load", {prog_cnt, swallow_cnt}, {12'hC35, 6'h2B});
        send_bit(1'b0);
        chk("R5 follows shift", {prog_cnt, swallow_cnt}, {1'b0, 17'({12'hC35, 6'h2B} >> 1)});
        chk("R5 ref untouched", ref_ratio, exp_r);
        ser_le = 1'b0;
        wait_clk(GAP);

        // R1 no serial clock edge: data toggling does nothing
        ser_dat = 1'b1;
        wait_clk(GAP);
        pulse_le();
        chk("R1 no edge no shift", {prog_cnt, swallow_cnt}, {1'b0, 17'({12'hC35, 6'h2B} >> 1)});

        // R7 reset after use
        rst = 1'b1;
        wait_clk(2);
        rst = 1'b0;
        wait_clk(1);
        chk("R7 cleared", {ref_ratio, swallow_cnt, prog_cnt, ref_valid, main_valid}, 0);
      end
      begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule